// File: doc/BRIEF.md
# Sound Processor Slot Schedule Sequencer

This block is the timing skeleton of an eight-voice sample-playback sound engine. A sample period is split into 32 ticks. Each tick lasts a parameterised number of enabled clocks, 24 by default. On every tick the block raises registered one-clock strobes. The strobes name which pipeline stage of which voice runs, which echo-unit step runs and which housekeeping step runs. A pulse also marks the start of each sample period. The voice, echo and envelope datapaths sit outside this block and use these strobes as their enables.

Each voice has nine pipeline stages, and each voice runs three ticks behind the previous one. The pipelines of the voices overlap, so up to three voices are active on one tick. Voice 0 does not follow the regular pattern. Its third stage is split into three parts, one on each of three separate ticks. Its later stages wrap around into the next sample period. The echo and housekeeping steps use fixed slots at the end of the period. Software has no access, and no state is kept beyond the two counters.

Top module: `sdsp_slot_sequencer`

## Requirements
- R1: After synchronous reset every output is low, and both the tick counter and the clock-in-tick counter are zero. The first clock with `ce` high after reset opens tick 0.
- R2: A tick spans `TICK_CLKS` clocks on which `ce` is high. Clocks with `ce` low do not advance either counter. On the clock after a `ce`-low clock every output is low.
- R3: `sample_o` pulses once per 32 ticks, for tick 0 only.
- R4: Each strobe is registered. It is high for exactly one clock: the clock after the enabled clock that opens its tick.
- R5: For voices 1 to 7, stage k (k = 2..9) runs at tick (3v + k - 5) mod 32. For voices 2 to 7, stage 1 runs at tick (3v - 7) mod 32. The stage strobe of voice v stage k is bit v*9 + k - 1 of `voice_stage_o`.
- R6: Voice 0 runs stage 1 at tick 17, stage 2 at tick 21, stage 4 at tick 31, and stages 5 to 9 at ticks 0 to 4. Its stage-3 bit (bit 2) never rises. The three parts of its split stage appear instead on `split_o` bits 0, 1 and 2, at ticks 22, 25 and 30.
- R7: Voice 1 runs stage 1 at tick 20.
- R8: `echo_o` bit i marks echo step 22 + i, which runs at tick 22 + i (i = 0..8).
- R9: `misc_o` bit i marks housekeeping step 27 + i, which runs at tick 27 + i (i = 0..3).
- R10: Tick 26 carries only echo step 26. No voice, split or housekeeping strobe rises on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; each high clock counts toward a tick |
| voice_stage_o | output | 72 | Voice-stage strobes, bit v*9 + k - 1 for voice v, stage k |
| split_o | output | 3 | Strobes for the three parts of voice 0's split stage |
| echo_o | output | 9 | Echo step strobes, bit i for step 22 + i |
| misc_o | output | 4 | Housekeeping step strobes, bit i for step 27 + i |
| sample_o | output | 1 | Start-of-sample pulse |

## Verification
Every strobe is due on the clock after the enabled clock that opens its tick, because only the output register lies between the counters and the ports. The bench model advances its own tick and phase counts on each rising edge from the `ce` value it drove. It then predicts the outputs for the edge that follows. All outputs are compared at every falling edge, half a period after they settle. Irregular `ce` patterns and enable-low gaps move the tick boundaries around, and the same one-clock latency still has to hold for them.

// File: rtl/sdsp_sched_pkg.sv
package sdsp_sched_pkg;

   localparam int SCHED_SLOTS  = 32;
   localparam int SCHED_VOICES = 8;
   localparam int SCHED_STAGES = 9;
   localparam int ECHO_FIRST   = 22;
   localparam int MISC_FIRST   = 27;

   // Tick on which voice v runs stage k; -1 when that stage is split.
   function automatic int stage_tick(input int v, input int k);
      int t;
      if (v == 0) begin
         case (k)
            1:       t = 17;
            2:       t = 21;
            3:       t = -1;
            4:       t = 31;
            default: t = k - 5;
         endcase
      end else if (k == 1) begin
         t = (v == 1) ? 20 : ((3 * v - 7 + SCHED_SLOTS) % SCHED_SLOTS);
      end else begin
         t = (3 * v + k - 5 + SCHED_SLOTS) % SCHED_SLOTS;
      end
      return t;
   endfunction

   // Tick of part p of voice 0's split stage.
   function automatic int split_tick(input int p);
      int t;
      case (p)
         0:       t = 22;
         1:       t = 25;
         default: t = 30;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/sdsp_tick_timer.sv
module sdsp_tick_timer #(
   parameter int TICK_CLKS = 24
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   output logic tick_start
);

   if (TICK_CLKS < 1) begin : g_bad_len
      $error("TICK_CLKS must be at least 1");
   end

   if (TICK_CLKS == 1) begin : g_every
      assign tick_start = ce;
   end else begin : g_count
      localparam int PH_W = $clog2(TICK_CLKS);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_CLKS - 1);

      logic [PH_W-1:0] phase_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            phase_q <= '0;
         end else if (ce) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
         end
      end

      assign tick_start = ce && (phase_q == '0);

      // R2
      phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
         phase_q <= PH_LAST);

      // R2
      phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
         !ce |=> $stable(phase_q));
   end

endmodule

// File: rtl/sdsp_slot_counter.sv
module sdsp_slot_counter #(
   parameter int SLOTS  = 32,
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   output logic [SLOT_W-1:0] slot
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end

   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= '0;
      end else if (adv) begin
         slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end
   end

   assign slot = slot_q;

   // R3
   slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && slot_q == SLOT_LAST) |=> (slot_q == '0));

   // R2
   slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(slot_q));

endmodule

// File: rtl/sdsp_slot_decode.sv
module sdsp_slot_decode
   import sdsp_sched_pkg::*;
#(
   parameter int SLOTS       = 32,
   parameter int SLOT_W      = $clog2(SLOTS),
   parameter int NUM_VOICES  = 8,
   parameter int STAGES      = 9,
   parameter int SPLIT_PARTS = 3,
   parameter int ECHO_STEPS  = 9,
   parameter int MISC_STEPS  = 4,
   localparam int VS_W       = NUM_VOICES * STAGES
) (
   input  logic [SLOT_W-1:0]      slot_i,
   output logic [VS_W-1:0]        voice_o,
   output logic [SPLIT_PARTS-1:0] split_o,
   output logic [ECHO_STEPS-1:0]  echo_o,
   output logic [MISC_STEPS-1:0]  misc_o,
   output logic                   sample_o
);

   logic [31:0] slot_ext;
   assign slot_ext = 32'(slot_i);

   for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         localparam int TK = stage_tick(v, k + 1);
         if (TK < 0) begin : g_split_slot
            assign voice_o[v*STAGES + k] = 1'b0;
         end else begin : g_plain_slot
            assign voice_o[v*STAGES + k] = (slot_ext == 32'(TK));
         end
      end
   end

   for (genvar p = 0; p < SPLIT_PARTS; p++) begin : g_part
      assign split_o[p] = (slot_ext == 32'(split_tick(p)));
   end

   for (genvar e = 0; e < ECHO_STEPS; e++) begin : g_echo
      assign echo_o[e] = (slot_ext == 32'(ECHO_FIRST + e));
   end

   for (genvar m = 0; m < MISC_STEPS; m++) begin : g_misc
      assign misc_o[m] = (slot_ext == 32'(MISC_FIRST + m));
   end

   assign sample_o = (slot_i == '0);

endmodule

// File: rtl/sdsp_slot_sequencer.sv
module sdsp_slot_sequencer
   import sdsp_sched_pkg::*;
#(
   parameter int TICK_CLKS   = 24,
   parameter int SLOTS       = 32,
   parameter int NUM_VOICES  = 8,
   parameter int STAGES      = 9,
   parameter int SPLIT_PARTS = 3,
   parameter int ECHO_STEPS  = 9,
   parameter int MISC_STEPS  = 4,
   localparam int SLOT_W     = $clog2(SLOTS),
   localparam int VS_W       = NUM_VOICES * STAGES
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   ce,
   output logic [VS_W-1:0]        voice_stage_o,
   output logic [SPLIT_PARTS-1:0] split_o,
   output logic [ECHO_STEPS-1:0]  echo_o,
   output logic [MISC_STEPS-1:0]  misc_o,
   output logic                   sample_o
);

   if (SLOTS != SCHED_SLOTS || NUM_VOICES != SCHED_VOICES ||
       STAGES != SCHED_STAGES) begin : g_bad_shape
      $error("schedule is fixed at 32 slots, 8 voices, 9 stages");
   end
   if (SPLIT_PARTS != 3 || ECHO_STEPS != 9 || MISC_STEPS != 4) begin : g_bad_tail
      $error("tail step counts do not match the schedule");
   end

   logic              tick_start;
   logic [SLOT_W-1:0] slot;

   logic [VS_W-1:0]        dec_voice;
   logic [SPLIT_PARTS-1:0] dec_split;
   logic [ECHO_STEPS-1:0]  dec_echo;
   logic [MISC_STEPS-1:0]  dec_misc;
   logic                   dec_sample;

   sdsp_tick_timer #(
      .TICK_CLKS (TICK_CLKS)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .ce         (ce),
      .tick_start (tick_start)
   );

   sdsp_slot_counter #(
      .SLOTS  (SLOTS),
      .SLOT_W (SLOT_W)
   ) u_slots (
      .clk  (clk),
      .rst  (rst),
      .adv  (tick_start),
      .slot (slot)
   );

   sdsp_slot_decode #(
      .SLOTS       (SLOTS),
      .SLOT_W      (SLOT_W),
      .NUM_VOICES  (NUM_VOICES),
      .STAGES      (STAGES),
      .SPLIT_PARTS (SPLIT_PARTS),
      .ECHO_STEPS  (ECHO_STEPS),
      .MISC_STEPS  (MISC_STEPS)
   ) u_decode (
      .slot_i   (slot),
      .voice_o  (dec_voice),
      .split_o  (dec_split),
      .echo_o   (dec_echo),
      .misc_o   (dec_misc),
      .sample_o (dec_sample)
   );

   always_ff @(posedge clk) begin
      if (rst || !tick_start) begin
         voice_stage_o <= '0;
         split_o       <= '0;
         echo_o        <= '0;
         misc_o        <= '0;
         sample_o      <= 1'b0;
      end else begin
         voice_stage_o <= dec_voice;
         split_o       <= dec_split;
         echo_o        <= dec_echo;
         misc_o        <= dec_misc;
         sample_o      <= dec_sample;
      end
   end

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !ce |=> (voice_stage_o == '0 && split_o == '0 && echo_o == '0 &&
               misc_o == '0 && !sample_o));

   // R4
   sample_single_chk: assert property (@(posedge clk) disable iff (rst)
      sample_o |=> !sample_o);

   // R6
   sample_v0s5_chk: assert property (@(posedge clk) disable iff (rst)
      sample_o |-> voice_stage_o[4]);

   // R6
   split_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(split_o) && !voice_stage_o[2]);

   // R9
   misc_echo_chk: assert property (@(posedge clk) disable iff (rst)
      (misc_o != '0) |-> (echo_o[ECHO_STEPS-1 -: MISC_STEPS] == misc_o));

   // R10
   echo26_alone_chk: assert property (@(posedge clk) disable iff (rst)
      echo_o[4] |-> (voice_stage_o == '0 && split_o == '0 && misc_o == '0));

endmodule

// File: tb/test_sdsp_slot_sequencer.sv
module test_sdsp_slot_sequencer;

   localparam int TC = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ce  = 1'b0;

   logic [71:0] voice_stage_o;
   logic [2:0]  split_o;
   logic [8:0]  echo_o;
   logic [3:0]  misc_o;
   logic        sample_o;

   sdsp_slot_sequencer #(.TICK_CLKS(TC)) i_sdsp_slot_sequencer (
      .clk           (clk),
      .rst           (rst),
      .ce            (ce),
      .voice_stage_o (voice_stage_o),
      .split_o       (split_o),
      .echo_o        (echo_o),
      .misc_o        (misc_o),
      .sample_o      (sample_o)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference table, written per tick
   logic [71:0] ref_v [32];
   logic [2:0]  ref_s [32];
   logic [8:0]  ref_e [32];
   logic [3:0]  ref_m [32];

   task automatic put(input int t, input int v, input int k);
      ref_v[t][v*9 + k - 1] = 1'b1;
   endtask

   initial begin
      for (int t = 0; t < 32; t++) begin
         ref_v[t] = '0; ref_s[t] = '0; ref_e[t] = '0; ref_m[t] = '0;
      end
      put(0,0,5);  put(0,1,2);
      put(1,0,6);  put(1,1,3);
      put(2,0,7);  put(2,1,4);  put(2,3,1);
      put(3,0,8);  put(3,1,5);  put(3,2,2);
      put(4,0,9);  put(4,1,6);  put(4,2,3);
      put(5,1,7);  put(5,2,4);  put(5,4,1);
      put(6,1,8);  put(6,2,5);  put(6,3,2);
      put(7,1,9);  put(7,2,6);  put(7,3,3);
      put(8,2,7);  put(8,3,4);  put(8,5,1);
      put(9,2,8);  put(9,3,5);  put(9,4,2);
      put(10,2,9); put(10,3,6); put(10,4,3);
      put(11,3,7); put(11,4,4); put(11,6,1);
      put(12,3,8); put(12,4,5); put(12,5,2);
      put(13,3,9); put(13,4,6); put(13,5,3);
      put(14,4,7); put(14,5,4); put(14,7,1);
      put(15,4,8); put(15,5,5); put(15,6,2);
      put(16,4,9); put(16,5,6); put(16,6,3);
      put(17,0,1); put(17,5,7); put(17,6,4);
      put(18,5,8); put(18,6,5); put(18,7,2);
      put(19,5,9); put(19,6,6); put(19,7,3);
      put(20,1,1); put(20,6,7); put(20,7,4);
      put(21,6,8); put(21,7,5); put(21,0,2);
      put(22,6,9); put(22,7,6);
      put(23,7,7);
      put(24,7,8);
      put(25,7,9);
      put(31,0,4); put(31,2,1);
      ref_s[22][0] = 1'b1; ref_s[25][1] = 1'b1; ref_s[30][2] = 1'b1;
      for (int i = 0; i < 9; i++) ref_e[22 + i][i] = 1'b1;
      for (int i = 0; i < 4; i++) ref_m[27 + i][i] = 1'b1;
   end

   // behavioural model, advanced on each rising edge
   int ph = 0;
   int sl = 0;
   logic [71:0] e_v;
   logic [2:0]  e_s;
   logic [8:0]  e_e;
   logic [3:0]  e_m;
   logic        e_smp;

   always @(posedge clk) begin
      if (rst) begin
         ph = 0; sl = 0;
         e_v = '0; e_s = '0; e_e = '0; e_m = '0; e_smp = 1'b0;
      end else begin
         if (ce && ph == 0) begin
            e_v = ref_v[sl]; e_s = ref_s[sl]; e_e = ref_e[sl];
            e_m = ref_m[sl]; e_smp = (sl == 0);
            sl = (sl + 1) % 32;
         end else begin
            e_v = '0; e_s = '0; e_e = '0; e_m = '0; e_smp = 1'b0;
         end
         if (ce) ph = (ph + 1) % TC;
      end
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // compare every clock, half a period after the edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk(voice_stage_o[8:0] === e_v[8:0], "R6 voice0 stages",
             72'(voice_stage_o[8:0]), 72'(e_v[8:0]));
         chk(voice_stage_o[71:9] === e_v[71:9], "R5 R7 voices1-7",
             72'(voice_stage_o[71:9]), 72'(e_v[71:9]));
         chk(split_o === e_s, "R6 split", 72'(split_o), 72'(e_s));
         chk(echo_o === e_e, "R8 echo", 72'(echo_o), 72'(e_e));
         chk(misc_o === e_m, "R9 misc", 72'(misc_o), 72'(e_m));
         chk(sample_o === e_smp, "R3 sample", 72'(sample_o), 72'(e_smp));
         if (echo_o[4] === 1'b1)
            chk(voice_stage_o == '0 && split_o == '0 && misc_o == '0,
                "R10 tick26", voice_stage_o, '0);
      end
   end

   // pulse counts over one full period with ce held high
   int pulse_cnt [72];
   bit counting = 1'b0;
   always @(negedge clk) begin
      if (counting)
         for (int b = 0; b < 72; b++) if (voice_stage_o[b]) pulse_cnt[b]++;
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      for (int b = 0; b < 72; b++) pulse_cnt[b] = 0;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(voice_stage_o == '0 && split_o == '0 && echo_o == '0 &&
          misc_o == '0 && sample_o == 1'b0, "R1 reset outputs",
          voice_stage_o, '0);
      rst = 1'b0;
      ce  = 1'b1;
      @(negedge clk);
      // R1: first enabled clock opens tick 0
      chk(sample_o === 1'b1, "R1 first tick", 72'(sample_o), 72'd1);
      // R4: exactly one clock
      @(negedge clk);
      chk(sample_o === 1'b0 && voice_stage_o == '0, "R4 one clock",
          voice_stage_o, '0);
      while (!(sample_o === 1'b1)) @(negedge clk);
      counting = 1'b1;
      repeat (32 * TC) @(negedge clk);
      counting = 1'b0;
      for (int b = 0; b < 72; b++)
         if (b != 2)
            chk(pulse_cnt[b] == 1, "R4 one pulse per period",
                72'(pulse_cnt[b]), 72'd1);
      chk(pulse_cnt[2] == 0, "R6 v0 stage3 bit", 72'(pulse_cnt[2]), 72'd0);
      // irregular enables
      for (int i = 0; i < 6000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ce = lfsr[0] | lfsr[3];
         @(negedge clk);
      end
      // R2: enable held low
      ce = 1'b0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (i > 0)
            chk(voice_stage_o == '0 && echo_o == '0 && misc_o == '0 &&
                split_o == '0 && !sample_o, "R2 ce low", voice_stage_o, '0);
      end
      ce = 1'b1;
      repeat (500) @(negedge clk);
      // mid-run reset
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(voice_stage_o == '0 && sample_o == 1'b0 && echo_o == '0,
          "R1 reset again", voice_stage_o, '0);
      rst = 1'b0;
      @(negedge clk);
      chk(sample_o === 1'b1, "R1 restart at tick 0", 72'(sample_o), 72'd1);
      repeat (2 * 32 * TC) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule